// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block watches a UART receiver for silence. Each received character restarts a window counter. The counter advances on a 16x oversampling baud tick. When the line has been idle for the time it takes to receive two complete characters, the window expires. The length of a character follows the current frame setting: data length, parity on or off, and one or two stop bits.

What happens when the window expires depends on the transfer mode. When a DMA engine is not moving the data, a timeout is raised only if unread bytes are waiting in the receive FIFO. This tells software to collect a short tail of data. When a DMA engine is moving the data, a timeout is raised whether the FIFO is empty or not. In that mode the block also emits a one-cycle request that tells the DMA engine to stop on error. Software clears the timeout status by writing a one to the clear input. A new timeout can then occur only after another character arrives.

Top module: `rx_idle_timeout`

## Requirements
- R1: The window is 2 × frame_bits × 16 baud ticks. frame_bits = 1 start bit + (5 + `cfg_dlen`) data bits + `cfg_parity` + (`cfg_stop2` ? 2 : 1) stop bits, so a window lies between 224 and 384 ticks. `tout_status` reads 0 after window−1 ticks and 1 in the cycle after the tick that completes the window.
- R2: When `dma_mode` is 0 and `fifo_nonempty` is 1 on the completing tick, `tout_status` becomes 1.
- R3: When `dma_mode` is 0 and `fifo_nonempty` is 0 on the completing tick, `tout_status` stays 0 for the rest of that idle period.
- R4: When `dma_mode` is 1, the expiry sets `tout_status` whatever the value of `fifo_nonempty`.
- R5: `dma_stop` is a single-cycle pulse. It rises in the same cycle as the status update of a DMA-mode timeout, and it stays 0 for timeouts in non-DMA mode.
- R6: A `char_rx` pulse restarts the window from zero, including while a window is already running.
- R7: Expiry happens at most once per idle period. With no further `char_rx`, no later tick causes another timeout.
- R8: `tout_clr`=1 clears `tout_status` in the next cycle. If a timeout fires in the same cycle, the set wins. A clear does not re-arm detection.
- R9: A synchronous active-low `rst_n` clears the status, the window and the armed state. After reset, no timeout occurs until a character has been received.
- R10: The window advances only on cycles with `baud_tick`=1. Clock cycles without a tick leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | 16x oversampling tick, one cycle wide |
| char_rx | input | 1 | Pulse when the receiver completes a character |
| fifo_nonempty | input | 1 | Receive FIFO holds unread data |
| dma_mode | input | 1 | 1 = DMA moves receive data |
| cfg_dlen | input | 2 | Data length code, 0..3 = 5..8 bits |
| cfg_parity | input | 1 | Parity bit present |
| cfg_stop2 | input | 1 | Two stop bits |
| tout_clr | input | 1 | Write-one-to-clear of the timeout status |
| tout_status | output | 1 | Timeout status bit |
| dma_stop | output | 1 | One-cycle request to stop DMA on error |

## Verification
On every cycle, the assertions check the following:
- the restart to zero after a character and the freeze of the window between ticks;
- the disarm after expiry;
- that every rise of the status has a qualified expiry behind it;
- the pulse shape of the stop request and its link to DMA mode;
- the clear behaviour.

The exact window length for each frame setting, the no-rearm rule after a clear, and the absence of a timeout after reset without a character can only be shown by the bench's scenarios. These scenarios include long idle runs, restarts in the middle of a window, and a clear that collides with a firing tick.

// File: rtl/rto_pkg.sv
package rto_pkg;

  localparam int unsigned DLEN_W = 2;

  typedef struct packed {
    logic [DLEN_W-1:0] dlen;
    logic              parity;
    logic              stop2;
  } rto_frame_cfg_t;

  // Bits in one character: start + data + optional parity + stop bits.
  function automatic int unsigned rto_frame_bits(rto_frame_cfg_t c, int unsigned min_data);
    int unsigned bits;
    bits = 1 + min_data + int'(c.dlen) + int'(c.parity) + (c.stop2 ? 2 : 1);
    return bits;
  endfunction

  // Window length in oversampling ticks.
  function automatic int unsigned rto_window_ticks(int unsigned frame_bits,
                                                   int unsigned osr,
                                                   int unsigned frames);
    return frame_bits * osr * frames;
  endfunction

endpackage

// File: rtl/rto_limit_calc.sv
module rto_limit_calc
  import rto_pkg::*;
#(
  parameter int unsigned OSR      = 16,
  parameter int unsigned FRAMES   = 2,
  parameter int unsigned MIN_DATA = 5,
  parameter int unsigned CNT_W    = 9
) (
  input  rto_frame_cfg_t   cfg,
  output logic [CNT_W-1:0] limit
);
  int unsigned fbits;
  int unsigned ticks;

  always_comb begin
    fbits = rto_frame_bits(cfg, MIN_DATA);
    ticks = rto_window_ticks(fbits, OSR, FRAMES);
    limit = ticks[CNT_W-1:0];
  end
endmodule

// File: rtl/rto_window_cnt.sv
module rto_window_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             char_rx,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             expire
);
  logic [CNT_W:0] next_cnt;
  logic           reach;

  always_comb begin
    next_cnt = {1'b0, cnt} + 1'b1;
    reach    = next_cnt >= {1'b0, limit};
    expire   = armed && baud_tick && !char_rx && reach;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (char_rx) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed && baud_tick) begin
      if (reach) begin
        cnt   <= limit;
        armed <= 1'b0;
      end else begin
        cnt   <= next_cnt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rto_status.sv
module rto_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic fifo_nonempty,
  input  logic dma_mode,
  input  logic tout_clr,
  output logic fire,
  output logic tout_status,
  output logic dma_stop
);
  always_comb fire = expire && (dma_mode || fifo_nonempty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tout_status <= 1'b0;
      dma_stop    <= 1'b0;
    end else begin
      dma_stop <= fire && dma_mode;
      if (fire)          tout_status <= 1'b1;
      else if (tout_clr) tout_status <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rto_pkg::*;
#(
  parameter int unsigned OSR      = 16,
  parameter int unsigned FRAMES   = 2,
  parameter int unsigned MIN_DATA = 5,
  localparam int unsigned MAX_FRAME = 1 + MIN_DATA + (1 << DLEN_W) - 1 + 1 + 2,
  localparam int unsigned CNT_W     = $clog2(MAX_FRAME * OSR * FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              char_rx,
  input  logic              fifo_nonempty,
  input  logic              dma_mode,
  input  logic [DLEN_W-1:0] cfg_dlen,
  input  logic              cfg_parity,
  input  logic              cfg_stop2,
  input  logic              tout_clr,
  output logic              tout_status,
  output logic              dma_stop
);
  rto_frame_cfg_t   frame_cfg;
  logic [CNT_W-1:0] win_limit;
  logic [CNT_W-1:0] win_cnt;
  logic             win_armed;
  logic             win_expire;
  logic             fire_ev;

  always_comb frame_cfg = '{dlen: cfg_dlen, parity: cfg_parity, stop2: cfg_stop2};

  rto_limit_calc #(
    .OSR(OSR), .FRAMES(FRAMES), .MIN_DATA(MIN_DATA), .CNT_W(CNT_W)
  ) u_limit (
    .cfg   (frame_cfg),
    .limit (win_limit)
  );

  rto_window_cnt #(.CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .char_rx   (char_rx),
    .limit     (win_limit),
    .cnt       (win_cnt),
    .armed     (win_armed),
    .expire    (win_expire)
  );

  rto_status u_sts (
    .clk           (clk),
    .rst_n         (rst_n),
    .expire        (win_expire),
    .fifo_nonempty (fifo_nonempty),
    .dma_mode      (dma_mode),
    .tout_clr      (tout_clr),
    .fire          (fire_ev),
    .tout_status   (tout_status),
    .dma_stop      (dma_stop)
  );
endmodule

// File: rtl/rto_checker.sv
module rto_checker #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             char_rx,
  input logic             fifo_nonempty,
  input logic             dma_mode,
  input logic             tout_clr,
  input logic             tout_status,
  input logic             dma_stop,
  input logic [CNT_W-1:0] win_cnt,
  input logic [CNT_W-1:0] win_limit,
  input logic             win_armed,
  input logic             win_expire,
  input logic             fire_ev
);
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    char_rx |=> (win_cnt == '0));

  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !char_rx) |=> $stable(win_cnt));

  a_r7_expire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> (!win_armed && win_cnt == win_limit));

  a_r2_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev |=> tout_status);

  a_r3_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_status) |-> ($past(win_expire) && ($past(dma_mode) || $past(fifo_nonempty))));

  a_r5_stop_only_dma: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |-> ($past(dma_mode) && tout_status));

  a_r5_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |=> !dma_stop);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_clr && !fire_ev) |=> !tout_status);
endmodule

bind rx_idle_timeout rto_checker #(.CNT_W(CNT_W)) u_rto_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .baud_tick     (baud_tick),
  .char_rx       (char_rx),
  .fifo_nonempty (fifo_nonempty),
  .dma_mode      (dma_mode),
  .tout_clr      (tout_clr),
  .tout_status   (tout_status),
  .dma_stop      (dma_stop),
  .win_cnt       (win_cnt),
  .win_limit     (win_limit),
  .win_armed     (win_armed),
  .win_expire    (win_expire),
  .fire_ev       (fire_ev)
);

// File: tb/test_rx_idle_timeout.sv
module test_rx_idle_timeout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       char_rx = 1'b0;
  logic       fifo_nonempty = 1'b0;
  logic       dma_mode = 1'b0;
  logic [1:0] cfg_dlen = 2'd3;
  logic       cfg_parity = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       tout_clr = 1'b0;
  logic       tout_status;
  logic       dma_stop;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // scoreboard queues: expected {status, stop} and requirement tag
  logic [1:0] q_exp[$];
  string      q_tag[$];
  string      cur_tag = "R9";

  // bench reference state
  int m_elapsed = 0;
  bit m_live = 1'b0;
  bit m_status = 1'b0;
  bit m_stop = 1'b0;

  always #2.5 clk = ~clk;

  rx_idle_timeout i_rx_idle_timeout (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .char_rx(char_rx),
    .fifo_nonempty(fifo_nonempty), .dma_mode(dma_mode), .cfg_dlen(cfg_dlen),
    .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2), .tout_clr(tout_clr),
    .tout_status(tout_status), .dma_stop(dma_stop)
  );

  // Window from R1: 32 ticks per bit over (7 + dlen + parity + extra stop).
  function automatic int window_len();
    return 32 * (7 + int'(cfg_dlen) + int'(cfg_parity) + int'(cfg_stop2));
  endfunction

  // Driver: one clock with given inputs, then push the expectation.
  task automatic step(bit tk, bit ch, bit clr);
    bit fire;
    baud_tick = tk;
    char_rx   = ch;
    tout_clr  = clr;
    @(posedge clk);
    fire = 1'b0;
    if (!rst_n) begin
      m_elapsed = 0; m_live = 1'b0; m_status = 1'b0; m_stop = 1'b0;
    end else begin
      if (ch) begin
        m_elapsed = 0; m_live = 1'b1;
      end else if (tk && m_live) begin
        m_elapsed++;
        if (m_elapsed == window_len()) begin
          m_live = 1'b0;
          fire = dma_mode || fifo_nonempty;
        end
      end
      m_stop = fire && dma_mode;
      if (fire) m_status = 1'b1;
      else if (clr) m_status = 1'b0;
    end
    q_exp.push_back({m_status, m_stop});
    q_tag.push_back(cur_tag);
    @(negedge clk);
    baud_tick = 1'b0; char_rx = 1'b0; tout_clr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
    end
  endtask

  // Monitor: compares outputs away from the active edge.
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      tests++;
      if ({tout_status, dma_stop} !== e) begin
        fails++;
        $display("FAIL %s: status,stop actual %b%b expected %b%b at cycle %0d",
                 t, tout_status, dma_stop, e[1], e[0], cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9: reset state, then no timeout without a received character
    cur_tag = "R9";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    dma_mode = 1'b1;
    idle(400);

    // R1, R2, R5: non-DMA with data, 8N1 (320 ticks), no stop pulse
    cur_tag = "R1,R2,R5";
    dma_mode = 1'b0; fifo_nonempty = 1'b1;
    step(1'b0, 1'b1, 1'b0);
    idle(330);

    // R8: clear, then no re-arm without a character (R7)
    cur_tag = "R8,R7";
    step(1'b0, 1'b0, 1'b1);
    idle(400);

    // R3: non-DMA with empty FIFO never sets
    cur_tag = "R3";
    fifo_nonempty = 1'b0;
    step(1'b0, 1'b1, 1'b0);
    idle(400);
    fifo_nonempty = 1'b1;
    idle(50);

    // R4, R5: DMA mode with empty FIFO, 5N1 (224 ticks)
    cur_tag = "R4,R5";
    fifo_nonempty = 1'b0; dma_mode = 1'b1;
    cfg_dlen = 2'd0;
    step(1'b0, 1'b1, 1'b0);
    idle(240);
    step(1'b0, 1'b0, 1'b1);

    // R6: restart mid-window, 8N1 (320)
    cur_tag = "R6";
    cfg_dlen = 2'd3;
    step(1'b0, 1'b1, 1'b0);
    idle(200);
    step(1'b0, 1'b1, 1'b0);
    idle(200);
    idle(130);

    // R8: clear colliding with the firing tick, 8E2 (384)
    cur_tag = "R8,R1";
    cfg_parity = 1'b1; cfg_stop2 = 1'b1;
    step(1'b0, 1'b1, 1'b1);
    idle(383);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);

    // R10: cycles without ticks do not advance the window
    cur_tag = "R10";
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 1000; i++) step(1'b0, 1'b0, 1'b0);
    idle(390);
    step(1'b0, 1'b0, 1'b1);

    // R9: reset in the middle of a window leaves no timeout pending
    cur_tag = "R9";
    step(1'b0, 1'b1, 1'b0);
    idle(100);
    rst_n = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    idle(400);

    // R7: DMA timeout fires once, later ticks do nothing
    cur_tag = "R7";
    step(1'b0, 1'b1, 1'b0);
    idle(384);
    step(1'b0, 1'b0, 1'b1);
    idle(400);

    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule